// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This controller connects a synchronous host request port to an asynchronous static RAM with a 16-bit data path. The host presents an address, write data, a byte-lane mask, a read/write flag and a write-termination choice, and it holds a valid strobe until the controller accepts the request. The controller then runs one complete memory cycle on active-low chip-select, output-enable and write-enable pins and a shared bidirectional data bus. It reports completion with a single-cycle done pulse, and read data is returned alongside that pulse.

Each byte lane has its own chip select and write enable, so the memory can be used sixteen bits wide or one byte at a time. The length of every phase is counted in system clocks. Each count comes from a nanosecond minimum given as a parameter and is rounded up against the clock-period parameter, with a floor of one clock. For every write, the host chooses at run time which strobe closes the write: the write-enable edge or the chip-select edge.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, all chip selects, write enables and output enable are high, the data bus is not driven, `req_ready` is 1 and `rsp_done` is 0.
- R2: A read with a non-zero mask keeps output enable low, write enables high and the chip select of each masked lane low for N_RD cycles. The bus is sampled in the last of those cycles, and a set mask bit i returns byte i, which is data bits 8i+7..8i.
- R3: N_RD is the largest of ceil(T_AA/P), ceil(T_RC/P) and ceil(T_OE/P), with a floor of 1. `rsp_done` is high in cycle N_RD+1, counted from the first cycle after acceptance.
- R4: With `req_term_cs`=0, a write has three phases. Setup lasts 1 cycle with the selected chip selects low and write enables high. The pulse lasts N_WP cycles with the selected chip selects and write enables both low. Hold lasts N_WH cycles with the chip selects still low and the write enables high.
- R5: With `req_term_cs`=1, a write has three phases. Setup lasts 1 cycle with the selected write enables low and the chip selects high. The pulse lasts N_WP cycles with both low. Hold lasts N_WH cycles with the chip selects high and the write enables still low.
- R6: N_WP is the largest of ceil(T_WP/P), ceil(T_AW/P) and ceil(T_DW/P). N_WH is the larger of 1 and ceil(T_WC/P)-1-N_WP. The write's `rsp_done` is high in cycle N_WP+N_WH+2.
- R7: The controller drives data only in the pulse and hold phases of a write. Output enable is never low while any write enable is low.
- R8: After every read, the controller stays idle for N_TURN = ceil(T_HZ/P) cycles (at least 1) before `req_ready` returns, so a following write cannot meet a bus that is still being released.
- R9: A mask bit of 0 keeps that lane's chip select and write enable high for the whole cycle. That lane's memory byte stays unchanged, and its read data byte returns 0.
- R10: An all-zero mask causes no strobe at all. `rsp_done` rises in the next cycle, and `req_ready` comes back one cycle after that.
- R11: `mem_addr` holds the accepted address and stays stable for as long as any strobe is active.
- R12: `rsp_done` is a single-cycle pulse. `req_ready` is high only when the controller is idle and no done pulse is showing, and after a write it returns in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_term_cs | input | 1 | 1 = chip select closes the write, 0 = write enable closes it |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8*LANES | Write data |
| req_be | input | LANES | Byte-lane mask, bit i selects data bits 8i+7..8i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*LANES | Read data, valid while rsp_done is high after a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | LANES | Per-lane chip select, active low |
| mem_we_n | output | LANES | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq | inout | 8*LANES | Bidirectional memory data bus |

## Verification
If the sequencer enters the wrong state or loads the wrong phase count, the strobe pins show it in the very next cycle, because they are registered directly from the next-state decode. The bench compares the pin pattern in every cycle of every operation against an arithmetic schedule. A lane gate that is wrong or a write edge that is misplaced leaves a byte of the memory model stale or corrupted, and the readback exposes it within a few operations. A turnaround or done counter that is off by one moves `req_ready` or `rsp_done` by a cycle, and the cycle-exact comparison catches it inside the same operation.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   // Phase state of the memory cycle sequencer.
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WSET,
      ST_WPUL,
      ST_WHLD
   } sramc_state_e;

   // Nanoseconds to clocks, rounded up, never below one clock.
   function automatic int clk_count(input int t_ns, input int period_ns);
      int c;
      c = (t_ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sramc_seq.sv
module sramc_seq
   import sramc_pkg::*;
#(
   parameter int N_RD   = 2,
   parameter int N_WP   = 2,
   parameter int N_WH   = 1,
   parameter int N_TURN = 1,
   parameter int CNT_W  = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic         req_write,
   input  logic         req_be_any,
   output logic         req_ready,
   output logic         accept,
   output logic         capture,
   output logic         done,
   output sramc_state_e state_d
);

   localparam logic [CNT_W-1:0] C_RD   = CNT_W'(N_RD - 1);
   localparam logic [CNT_W-1:0] C_WP   = CNT_W'(N_WP - 1);
   localparam logic [CNT_W-1:0] C_WH   = CNT_W'(N_WH - 1);
   localparam logic [CNT_W-1:0] C_TURN = CNT_W'(N_TURN - 1);

   sramc_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             done_d;

   // Ready only when idle and the previous done pulse has been shown.
   assign req_ready = (state_q == ST_IDLE) && !done;
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      done_d  = 1'b0;
      capture = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               if (!req_be_any) begin
                  done_d = 1'b1;
               end else if (req_write) begin
                  state_d = ST_WSET;
                  cnt_d   = '0;
               end else begin
                  state_d = ST_RD;
                  cnt_d   = C_RD;
               end
            end
         end
         ST_RD: begin
            if (cnt_q == '0) begin
               capture = 1'b1;
               done_d  = 1'b1;
               state_d = ST_TURN;
               cnt_d   = C_TURN;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_TURN: begin
            if (cnt_q == '0) state_d = ST_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_WSET: begin
            state_d = ST_WPUL;
            cnt_d   = C_WP;
         end
         ST_WPUL: begin
            if (cnt_q == '0) begin
               state_d = ST_WHLD;
               cnt_d   = C_WH;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_WHLD: begin
            if (cnt_q == '0) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         done    <= done_d;
      end
   end

   // R12: completion is never stretched over two cycles.
   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: an empty mask finishes on the next cycle.
   a_r10_zero_mask_done: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_be_any) |=> done);

endmodule

// File: rtl/sramc_lane.sv
module sramc_lane
   import sramc_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sramc_state_e      state_d,
   input  logic              lane_en_d,
   input  logic              lane_en_q,
   input  logic              term_cs_d,
   input  logic [LANE_W-1:0] wdata,
   input  logic              capture,
   input  logic              oe_n,
   output logic              cs_n,
   output logic              we_n,
   output logic [LANE_W-1:0] rdata,
   inout  wire  [LANE_W-1:0] dq
);

   logic cs_low_d;
   logic we_low_d;
   logic drv_d;
   logic drv_q;

   // Strobe pattern per phase; term_cs_d chooses which strobe frames the pulse.
   always_comb begin
      cs_low_d = 1'b0;
      we_low_d = 1'b0;
      drv_d    = 1'b0;
      unique case (state_d)
         ST_RD:   cs_low_d = 1'b1;
         ST_WSET: begin
            cs_low_d = !term_cs_d;
            we_low_d = term_cs_d;
         end
         ST_WPUL: begin
            cs_low_d = 1'b1;
            we_low_d = 1'b1;
            drv_d    = 1'b1;
         end
         ST_WHLD: begin
            cs_low_d = !term_cs_d;
            we_low_d = term_cs_d;
            drv_d    = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n  <= 1'b1;
         we_n  <= 1'b1;
         drv_q <= 1'b0;
         rdata <= '0;
      end else begin
         cs_n  <= !(cs_low_d && lane_en_d);
         we_n  <= !(we_low_d && lane_en_d);
         drv_q <= drv_d && lane_en_d;
         if (capture) rdata <= lane_en_q ? dq : '0;
      end
   end

   assign dq = drv_q ? wdata : 'z;

   // R9: an unselected lane never shows a strobe or drives the bus.
   a_r9_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n || !we_n || drv_q) |-> lane_en_q);

   // R7: no write data on the bus while the memory may be driving it.
   a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      drv_q |-> oe_n);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sramc_pkg::*;
#(
   parameter int LANES         = 2,
   parameter int ADDR_W        = 17,
   parameter int CLK_PERIOD_NS = 20,
   parameter int T_RC_NS       = 35,
   parameter int T_AA_NS       = 35,
   parameter int T_OE_NS       = 20,
   parameter int T_WC_NS       = 35,
   parameter int T_WP_NS       = 25,
   parameter int T_AW_NS       = 25,
   parameter int T_DW_NS       = 20,
   parameter int T_HZ_NS       = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic                 req_term_cs,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [8*LANES-1:0]   req_wdata,
   input  logic [LANES-1:0]     req_be,
   output logic                 rsp_done,
   output logic [8*LANES-1:0]   rsp_rdata,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [LANES-1:0]     mem_cs_n,
   output logic [LANES-1:0]     mem_we_n,
   output logic                 mem_oe_n,
   inout  wire  [8*LANES-1:0]   mem_dq
);

   localparam int P      = CLK_PERIOD_NS;
   localparam int DATA_W = 8 * LANES;
   localparam int N_RD   = imax(imax(clk_count(T_AA_NS, P), clk_count(T_RC_NS, P)),
                                clk_count(T_OE_NS, P));
   localparam int N_WP   = imax(imax(clk_count(T_WP_NS, P), clk_count(T_AW_NS, P)),
                                clk_count(T_DW_NS, P));
   localparam int N_WC   = clk_count(T_WC_NS, P);
   localparam int N_WH   = imax(1, N_WC - 1 - N_WP);
   localparam int N_TURN = clk_count(T_HZ_NS, P);
   localparam int N_MAX  = imax(imax(N_RD, N_WP), imax(N_WH, N_TURN));
   localparam int CNT_W  = (N_MAX < 2) ? 1 : $clog2(N_MAX);
   localparam int PL_W   = $clog2(N_WP + 2);

   // Elaboration-time parameter checks.
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be positive");
      end
   endgenerate

   sramc_state_e         state_d;
   logic                 accept;
   logic                 capture;
   logic [DATA_W-1:0]    wdata_q;
   logic [LANES-1:0]     be_q;
   logic [LANES-1:0]     be_d;
   logic                 term_q;
   logic                 term_d;

   sramc_seq #(
      .N_RD   (N_RD),
      .N_WP   (N_WP),
      .N_WH   (N_WH),
      .N_TURN (N_TURN),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_be_any (|req_be),
      .req_ready  (req_ready),
      .accept     (accept),
      .capture    (capture),
      .done       (rsp_done),
      .state_d    (state_d)
   );

   // Lane controls for the next cycle must see the mask being accepted now.
   assign be_d   = accept ? req_be      : be_q;
   assign term_d = accept ? req_term_cs : term_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         wdata_q  <= '0;
         be_q     <= '0;
         term_q   <= 1'b0;
         mem_oe_n <= 1'b1;
      end else begin
         if (accept) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
            be_q     <= req_be;
            term_q   <= req_term_cs;
         end
         mem_oe_n <= (state_d != ST_RD);
      end
   end

   generate
      for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
         sramc_lane #(.LANE_W(8)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .state_d   (state_d),
            .lane_en_d (be_d[gi]),
            .lane_en_q (be_q[gi]),
            .term_cs_d (term_d),
            .wdata     (wdata_q[8*gi +: 8]),
            .capture   (capture),
            .oe_n      (mem_oe_n),
            .cs_n      (mem_cs_n[gi]),
            .we_n      (mem_we_n[gi]),
            .rdata     (rsp_rdata[8*gi +: 8]),
            .dq        (mem_dq[8*gi +: 8])
         );
      end
   endgenerate

   // Observation of the write pulse width at the pins.
   logic            strobe_act;
   logic            pul_now;
   logic            pul_prev;
   logic [PL_W-1:0] pul_len;

   assign strobe_act = !(&mem_cs_n) || !(&mem_we_n);
   assign pul_now    = |(~mem_cs_n & ~mem_we_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pul_prev <= 1'b0;
         pul_len  <= '0;
      end else begin
         pul_prev <= pul_now;
         pul_len  <= pul_now ? pul_len + 1'b1 : '0;
      end
   end

   // R7: output enable and write enable are never low together.
   a_r7_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (&mem_we_n));

   // R11: the address does not move while a strobe is active.
   a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_act && $past(strobe_act)) |-> $stable(mem_addr));

   // R6: each write pulse lasts exactly N_WP clocks.
   a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      (pul_prev && !pul_now) |-> (pul_len == PL_W'(N_WP)));

   // R8: the end of a read is followed by a cycle that is not ready.
   a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> !req_ready);

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

   localparam int P = 20;

   function automatic int cdiv(input int t);
      int c;
      c = (t + P - 1) / P;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int NRD   = mx(mx(cdiv(35), cdiv(35)), cdiv(20));
   localparam int NWP   = mx(mx(cdiv(25), cdiv(25)), cdiv(20));
   localparam int NWH   = mx(1, cdiv(35) - 1 - NWP);
   localparam int NTURN = cdiv(20);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_term_cs = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [16:0] mem_addr;
   logic [1:0]  mem_cs_n;
   logic [1:0]  mem_we_n;
   logic        mem_oe_n;
   wire  [15:0] mem_dq;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   sram_async_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_term_cs (req_term_cs),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_be      (req_be),
      .rsp_done    (rsp_done),
      .rsp_rdata   (rsp_rdata),
      .mem_addr    (mem_addr),
      .mem_cs_n    (mem_cs_n),
      .mem_we_n    (mem_we_n),
      .mem_oe_n    (mem_oe_n),
      .mem_dq      (mem_dq)
   );

   // Memory model: two byte lanes, indexed by the low address byte.
   logic [7:0] mm [0:1][0:255];
   logic [7:0] sh [0:1][0:255];
   logic [1:0] pact;

   for (genvar g = 0; g < 2; g++) begin : g_model
      assign mem_dq[8*g +: 8] = (!mem_cs_n[g] && !mem_oe_n && mem_we_n[g]) ?
                                mm[g][mem_addr[7:0]] : 8'bz;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < 256; a++) begin
            mm[0][a] = 8'(a) ^ 8'h5A;
            mm[1][a] = ~8'(a);
         end
         pact = 2'b00;
      end else begin
         for (int i = 0; i < 2; i++) begin
            if (pact[i] && !(!mem_cs_n[i] && !mem_we_n[i]))
               mm[i][mem_addr[7:0]] = mem_dq[8*i +: 8];
            pact[i] = !mem_cs_n[i] && !mem_we_n[i];
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic do_op(input bit wr, input bit tcs, input logic [16:0] a,
                        input logic [15:0] d, input logic [1:0] be);
      int done_k;
      int ready_k;
      string ts;
      string td;
      string tr;
      logic [1:0] ecs;
      logic [1:0] ewe;
      logic       eoe;
      if (be == 2'b00) begin
         done_k = 1; ready_k = 2; ts = "R10"; td = "R10"; tr = "R10";
      end else if (wr) begin
         done_k = NWP + NWH + 2; ready_k = done_k + 1;
         ts = tcs ? "R5" : "R4"; td = "R6"; tr = "R12";
      end else begin
         done_k = NRD + 1; ready_k = NRD + NTURN + 1;
         ts = "R2"; td = "R3"; tr = "R8";
      end
      if (be == 2'b01 || be == 2'b10) ts = {ts, "/R9"};
      req_write   = wr;
      req_term_cs = tcs;
      req_addr    = a;
      req_wdata   = d;
      req_be      = be;
      req_valid   = 1'b1;
      @(posedge clk);
      for (int k = 1; k <= ready_k; k++) begin
         @(negedge clk);
         if (k == 1) req_valid = 1'b0;
         ecs = 2'b11; ewe = 2'b11; eoe = 1'b1;
         if (be != 2'b00) begin
            if (!wr) begin
               if (k <= NRD) begin ecs = ~be; eoe = 1'b0; end
            end else if (k == 1) begin
               if (tcs) ewe = ~be; else ecs = ~be;
            end else if (k <= NWP + 1) begin
               ecs = ~be; ewe = ~be;
            end else if (k <= NWP + NWH + 1) begin
               if (tcs) ewe = ~be; else ecs = ~be;
            end
         end
         chk({mem_cs_n, mem_we_n, mem_oe_n} == {ecs, ewe, eoe}, ts,
             $sformatf("strobes cs/we/oe k=%0d", k),
             {mem_cs_n, mem_we_n, mem_oe_n}, {ecs, ewe, eoe});
         chk(rsp_done == (k == done_k), td, $sformatf("done k=%0d", k),
             rsp_done, (k == done_k));
         chk(req_ready == (k >= ready_k), tr, $sformatf("ready k=%0d", k),
             req_ready, (k >= ready_k));
         chk(mem_oe_n || (&mem_we_n), "R7", "oe low with write enable low",
             {mem_oe_n, mem_we_n}, 3'b111);
         if (!(&mem_cs_n) || !(&mem_we_n))
            chk(mem_addr == a, "R11", "address during strobe", mem_addr, a);
         if (!wr && be != 2'b00 && k == done_k) begin
            for (int i = 0; i < 2; i++) begin
               logic [7:0] eb;
               eb = be[i] ? sh[i][a[7:0]] : 8'h00;
               chk(rsp_rdata[8*i +: 8] == eb, be[i] ? "R2" : "R9",
                   $sformatf("read lane %0d addr %0h", i, a),
                   rsp_rdata[8*i +: 8], eb);
            end
         end
      end
      if (wr) begin
         if (be[0]) sh[0][a[7:0]] = d[7:0];
         if (be[1]) sh[1][a[7:0]] = d[15:8];
      end
   endtask

   function automatic logic [16:0] addr_of(input int j);
      return 17'((j << 8) | ((j * 17 + 3) & 255));
   endfunction

   initial begin
      for (int a = 0; a < 256; a++) begin
         sh[0][a] = 8'(a) ^ 8'h5A;
         sh[1][a] = ~8'(a);
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk({mem_cs_n, mem_we_n, mem_oe_n} == 5'h1F, "R1", "strobes in reset",
          {mem_cs_n, mem_we_n, mem_oe_n}, 5'h1F);
      rst_n = 1'b1;
      @(negedge clk);
      chk({mem_cs_n, mem_we_n, mem_oe_n} == 5'h1F, "R1", "strobes after reset",
          {mem_cs_n, mem_we_n, mem_oe_n}, 5'h1F);
      chk(req_ready == 1'b1 && rsp_done == 1'b0, "R1", "ready/done after reset",
          {req_ready, rsp_done}, 2'b10);

      // Untouched locations read back their initial contents.
      do_op(1'b0, 1'b0, 17'h1_00F0, 16'h0, 2'b11);

      // Writes across both termination modes and all masks.
      for (int j = 0; j < 16; j++)
         do_op(1'b1, j[0], addr_of(j),
               {8'(j * 29 + 1), 8'(j * 13 + 7)}, 2'((j >> 1) & 3));

      // Readback, full width and each mask pattern.
      for (int j = 0; j < 16; j++) begin
         do_op(1'b0, 1'b0, addr_of(j), 16'h0, 2'b11);
         do_op(1'b0, 1'b0, addr_of(j), 16'h0, 2'(j & 3));
      end

      // Read followed at once by a write, then check the result.
      for (int j = 0; j < 4; j++) begin
         do_op(1'b0, 1'b0, addr_of(j), 16'h0, 2'b11);
         do_op(1'b1, j[0], addr_of(j), {8'(j + 8'hC0), 8'(j + 8'h30)}, 2'b11);
         do_op(1'b0, 1'b0, addr_of(j), 16'h0, 2'b11);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule